// File: doc/BRIEF.md
# Double-Buffered Serial DAC Word Receiver

This block is the digital front end of a 16-bit digital-to-analog converter. A host sends words over a three-wire link: an active-low frame strobe, a serial clock and a data line. The block shifts in each word, most significant bit first, on the falling edges of the serial clock. When a frame closes after exactly 16 bits, the word is stored in an input register. A second register, the DAC register, drives the converter code. Words move from the first register to the second under the control of an active-low load line.

All link pins are treated as asynchronous. Each pin passes through a two-flop synchronizer into a single fast system clock, and every edge is detected in that clock domain. The block has three other functions:
- A clear input forces the reported code to the offset-binary mid-scale value. This value is zero volts at the output.
- A power-down input raises a status flag.
- A serial output presents the shift register, so that several devices can be chained or the shifted data can be read back.

Top module: `sdac_link`

## Requirements
- R1: After reset, `dac_code` is 0x8000, `clr_flag` and `pd_flag` are 0, and `sdo` is 0.
- R2: A frame starts when `fs_n` falls. During the frame, each falling edge of `sck` shifts `sdi` into the shift register, MSB first. When `fs_n` rises after exactly 16 falling edges, the shifted word is copied into the input register.
- R3: While `ld_n` is high, a completed frame leaves `dac_code` unchanged. A falling edge of `ld_n` copies the input register into the DAC register.
- R4: If `ld_n` is already low when a valid frame closes, the DAC register takes the new word at the rising edge of `fs_n`.
- R5: A frame that closes after any count of falling `sck` edges other than 16 is discarded, and the input register keeps its previous word.
- R6: A falling edge of `clr_n` sets `clr_flag`, and `dac_code` then reads 0x8000. The input register and the DAC register keep their contents.
- R7: `clr_flag` stays set until the next DAC-register update. That update clears the flag, and `dac_code` again shows the DAC register.
- R8: While `pd_n` is low, `pd_flag` is 1 and `dac_code` is unchanged. Releasing `pd_n` clears the flag and leaves the registers intact.
- R9: At a falling edge of `fs_n`, `sdo` takes the shift-register MSB. After that, `sdo` changes only on rising edges of `sck`, where it takes the current MSB. During a 16-bit frame, the previous shift-register contents therefore leave on `sdo` MSB first, one bit per serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| fs_n | input | 1 | Active-low frame strobe |
| sck | input | 1 | Serial clock, idle high |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Active-low load of the DAC register |
| clr_n | input | 1 | Active-low clear, edge-triggered |
| pd_n | input | 1 | Active-low power-down |
| sdo | output | 1 | Serial data out, MSB of the shift register |
| dac_code | output | 16 | Code presented to the converter |
| clr_flag | output | 1 | Output forced to mid-scale by a clear |
| pd_flag | output | 1 | Power-down active |

## Verification
The assertions rely on the link pins being slow compared with the system clock. Each level of `sck` and `fs_n` must last at least three system clocks, so that every edge is seen once. `sdi` must be stable around the falling edge of `sck`. The stimulus follows these rules by holding each serial-clock phase for six system clocks. It changes `sdi` only while `sck` is high. It leaves several clocks between the frame strobe and the first or last serial edge, and between the last serial edge and the frame strobe. It never asserts `clr_n` or `ld_n` in the same clock as a frame closes.

// File: rtl/sdac_link.sv
module sdac_link #(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] CLR_CODE = {1'b1, {(WORD_W-1){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic              pd_n,
  output logic              sdo,
  output logic [WORD_W-1:0] dac_code,
  output logic              clr_flag,
  output logic              pd_flag
);
  localparam int CW = $clog2(WORD_W + 2);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);
  localparam logic [CW-1:0] OVER = CW'(WORD_W + 1);

  logic [2:0] fs_q, sck_q, ld_q, clr_q;
  logic [1:0] pd_q, sdi_q;
  logic [WORD_W-1:0] sh, in_reg, dac_reg;
  logic [CW-1:0] cnt;
  logic in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= '1;
      sck_q <= '1;
      ld_q  <= '1;
      clr_q <= '1;
      pd_q  <= '1;
      sdi_q <= '0;
    end else begin
      fs_q  <= {fs_q[1:0], fs_n};
      sck_q <= {sck_q[1:0], sck};
      ld_q  <= {ld_q[1:0], ld_n};
      clr_q <= {clr_q[1:0], clr_n};
      pd_q  <= {pd_q[0], pd_n};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  wire fs_fall  = fs_q[2] & ~fs_q[1];
  wire fs_rise  = ~fs_q[2] & fs_q[1];
  wire sck_fall = in_frame & sck_q[2] & ~sck_q[1];
  wire sck_rise = in_frame & ~sck_q[2] & sck_q[1];
  wire ld_low   = ~ld_q[1];
  wire ld_fall  = ld_q[2] & ~ld_q[1];
  wire clr_fall = clr_q[2] & ~clr_q[1];
  wire frame_ok = in_frame & fs_rise & (cnt == FULL);
  wire upd      = ld_fall | (frame_ok & ld_low);
  wire [WORD_W-1:0] next_in = frame_ok ? sh : in_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      sdo      <= 1'b0;
      in_reg   <= CLR_CODE;
      dac_reg  <= CLR_CODE;
      clr_flag <= 1'b0;
      pd_flag  <= 1'b0;
    end else begin
      if (fs_fall) begin
        in_frame <= 1'b1;
        cnt      <= '0;
        sdo      <= sh[WORD_W-1];
      end else if (fs_rise) begin
        in_frame <= 1'b0;
      end
      if (sck_fall) begin
        sh <= {sh[WORD_W-2:0], sdi_q[1]};
        if (cnt != OVER) cnt <= cnt + 1'b1;
      end
      if (sck_rise) sdo <= sh[WORD_W-1];
      if (frame_ok) in_reg <= sh;
      if (upd) dac_reg <= next_in;
      if (clr_fall) clr_flag <= 1'b1;
      else if (upd) clr_flag <= 1'b0;
      pd_flag <= ~pd_q[1];
    end
  end

  assign dac_code = clr_flag ? CLR_CODE : dac_reg;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |=> sh[0] == $past(sdi_q[1])); // R2
  AST_HOLD_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(dac_reg)); // R3
  AST_LOAD_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && ld_low && !clr_fall) |=> dac_code == $past(sh)); // R4
  AST_DROP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && in_frame && cnt != FULL) |=> $stable(in_reg)); // R5
  AST_CLR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (clr_flag && dac_code == CLR_CODE)); // R6
  AST_CLR_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fall && !frame_ok && !upd) |=> ($stable(in_reg) && $stable(dac_reg))); // R6
  AST_CLR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !upd) |=> clr_flag); // R7
  AST_PD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_q[1] |=> pd_flag); // R8
  AST_SDO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_rise && !fs_fall) |=> $stable(sdo)); // R9
endmodule

// File: tb/sdac_link_bench.sv
module sdac_link_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_n = 1'b1, sck = 1'b1, sdi = 1'b0, ld_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
  logic sdo, clr_flag, pd_flag;
  logic [15:0] dac_code;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] m_sh = '0, m_in = 16'h8000, m_dac = 16'h8000, got = '0;

  always #5 clk = ~clk;

  sdac_link u_sdac_link (
    .clk(clk), .rst_n(rst_n), .fs_n(fs_n), .sck(sck), .sdi(sdi), .ld_n(ld_n),
    .clr_n(clr_n), .pd_n(pd_n), .sdo(sdo), .dac_code(dac_code),
    .clr_flag(clr_flag), .pd_flag(pd_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    got = '0;
    fs_n = 1'b0;
    tick(6);
    for (int i = 0; i < n; i++) begin
      sdi = w[15 - (i % 16)];
      tick(6);
      if (i < 16) got[15 - i] = sdo;
      sck = 1'b0;
      m_sh = {m_sh[14:0], sdi};
      tick(6);
      sck = 1'b1;
    end
    tick(6);
    fs_n = 1'b1;
    tick(10);
  endtask

  task automatic pulse_ld();
    ld_n = 1'b0;
    tick(8);
    ld_n = 1'b1;
    tick(8);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] w, prev;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    check("R1 code", dac_code, 16'h8000);
    check("R1 clr_flag", {15'd0, clr_flag}, 16'd0);
    check("R1 pd_flag", {15'd0, pd_flag}, 16'd0);
    check("R1 sdo", {15'd0, sdo}, 16'd0);

    for (int k = 0; k < 20; k++) begin
      w = (k < 16) ? (16'h1 << k) : (16'hA5C3 ^ (16'(k) * 16'h3B1D));
      prev = m_sh;
      send(w, 16);
      m_in = w;
      check("R9 sdo shifts previous word", got, prev);
      check("R3 no update with load high", dac_code, m_dac);
      pulse_ld();
      m_dac = m_in;
      check("R2/R3 word after load edge", dac_code, w);
    end

    ld_n = 1'b0;
    tick(8);
    for (int k = 0; k < 8; k++) begin
      w = 16'hFFFF - 16'(k * 16'h1357);
      send(w, 16);
      m_in = w;
      m_dac = w;
      check("R4 update at frame close", dac_code, w);
    end
    ld_n = 1'b1;
    tick(8);

    for (int n = 0; n < 21; n++) begin
      if (n != 16) begin
        send(16'h5AA5 ^ 16'(n), n);
        pulse_ld();
        check("R5 short or long frame dropped", dac_code, m_in);
      end
    end

    send(16'h1234, 16);
    m_in = 16'h1234;
    pulse_ld();
    m_dac = m_in;
    clr_n = 1'b0;
    tick(8);
    check("R6 clear code", dac_code, 16'h8000);
    check("R6 clear flag", {15'd0, clr_flag}, 16'd1);
    clr_n = 1'b1;
    tick(8);
    pulse_ld();
    check("R6 registers kept", dac_code, 16'h1234);
    check("R7 flag cleared by update", {15'd0, clr_flag}, 16'd0);

    clr_n = 1'b0;
    tick(8);
    clr_n = 1'b1;
    tick(8);
    send(16'hBEEF, 16);
    m_in = 16'hBEEF;
    check("R7 flag held over frame", {15'd0, clr_flag}, 16'd1);
    check("R7 code held over frame", dac_code, 16'h8000);
    pulse_ld();
    check("R7 new word after update", dac_code, 16'hBEEF);
    check("R7 flag cleared", {15'd0, clr_flag}, 16'd0);

    pd_n = 1'b0;
    tick(8);
    check("R8 power-down flag", {15'd0, pd_flag}, 16'd1);
    check("R8 code kept in power-down", dac_code, 16'hBEEF);
    pd_n = 1'b1;
    tick(8);
    check("R8 flag released", {15'd0, pd_flag}, 16'd0);
    check("R8 code kept after release", dac_code, 16'hBEEF);

    done = 1'b1;
    finish_run();
  end
endmodule